// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block sits between a fast bus-clock register port and a bank of timer registers that live in a slower, unrelated functional clock. A bus write to one of the synchronised registers is parked in a bus-side holding register. A toggle handshake then carries it across to the functional domain, so the bus does not have to wait for the slow clock. Each synchronised register has its own write-pending flag. The flag rises when the bus writes the register and drops once the functional domain has taken the value and its acknowledge has come back. All flags can be read together from one status register.

An interface-control register selects the write mode. In posted mode a write finishes at once, unless the same register is still pending, in which case the bus is held off until that register's flag clears. In non-posted mode every write to a synchronised register holds the bus until its own handshake completes. Reads of a synchronised register return a bus-side shadow copy. The shadow changes only when a transfer completes, so a read-back after the flag clears confirms that the write has landed.

Top module: `psb_bridge`

## Requirements
- R1: After reset all pending flags are 0, all synchronised registers and their functional copies read 0, and the interface-control register reads 0x4 (posted mode).
- R2: Synchronised register i sits at bus address i, for i from 0 to 9, in this order: control, counter, reload, trigger, match, tick increment up, tick increment down, tick count, overflow mask set, overflow mask count. The cycle after a write to address i is accepted, bit i of the pending status register is 1.
- R3: Launch happens at the bus clock edge that accepts the write. The functional copy of that register takes the new value on the third functional clock edge after launch. The pending flag clears on the second bus clock edge after that.
- R4: Each functional-side update raises that register's update strobe for exactly one functional clock cycle, at the same edge as the value.
- R5: In posted mode, a write to a synchronised register whose flag is clear completes with ready high in its first cycle.
- R6: In posted mode, a write to a register whose flag is set holds ready low. The write is accepted in the first cycle the flag reads clear.
- R7: In non-posted mode, ready stays low from the first cycle of a synchronised write until that register's handshake has completed (including an earlier posted write still outstanding). When the write finishes, the register's flag reads 0 and the functional copy holds the new value.
- R8: The interface-control register is at address 15. Bit 2 is the posted-mode bit, and all other bits read 0. Writes to it complete in one cycle and take effect on the next write.
- R9: The pending status register is at address 14. Bit i is the flag of register i, and bits above 9 read 0. It is read-only: a write to it completes in one cycle and changes no flag.
- R10: A read of a synchronised register returns the value of its last completed transfer, so it shows the old value while the flag is set. Reads and accesses to addresses 10 to 13 never stall, and addresses 10 to 13 read 0.
- R11: The flags of different registers are independent. Writes to several registers in consecutive cycles are all accepted at once, and their flags are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| busRstN | input | 1 | Bus-domain asynchronous reset, active low |
| busSel | input | 1 | Access request; held with address and data until ready |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the addressed register |
| busReady | output | 1 | Access completes on a clock edge where it is high |
| funcClk | input | 1 | Functional clock, asynchronous to busClk |
| funcRstN | input | 1 | Functional-domain asynchronous reset, active low |
| funcRegs | output | NREG*DATA_W | Functional-domain copies, register i at bits i*DATA_W upward |
| funcWrStb | output | NREG | One functional-cycle pulse per register update |

## Verification
The properties assume that a bus master keeps busSel, busWr, busAddr and busWdata steady while ready is low. They also assume that both resets are asserted together. Without these, the non-posted stall check and the pending-rise check could blame the block for a request that changed under it. The stimulus drives every access from tasks that change the bus only after the completing edge. It releases both resets in the same instant. It runs the two clocks with edges that never coincide, so that the reference model's latency of three functional edges and two bus edges is exact.

// File: rtl/psb_pkg.sv
package psb_pkg;

  // Strobes from the access control to the register datapath
  typedef struct packed {
    logic launch;   // start a transfer for the register at busAddr
    logic ctlWr;    // write to the interface-control register
  } psbStb_t;

endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl #(
  parameter int NREG   = 10,
  parameter int ADDR_W = 4
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NREG-1:0]     pendVec,
  input  logic                postedMode,
  input  logic [ADDR_W-1:0]   ifcAddr,
  output logic                busReady,
  output psb_pkg::psbStb_t    stb
);

  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic isSync;
  logic writeSync;
  logic selPend;
  logic npBusy;

  assign isSync    = busAddr < NREG_A;
  assign writeSync = busSel && busWr && isSync;
  assign selPend   = isSync ? pendVec[busAddr] : 1'b0;

  always_comb begin
    stb.launch = writeSync && !selPend && (postedMode || !npBusy);
    stb.ctlWr  = busSel && busWr && (busAddr == ifcAddr);
    if (!writeSync)      busReady = 1'b1;
    else if (postedMode) busReady = !selPend;
    else                 busReady = npBusy && !selPend;
  end

  // Non-posted: first the launch, then wait for the round trip
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      npBusy <= 1'b0;
    end else if (writeSync && !postedMode) begin
      if (!npBusy && !selPend)     npBusy <= 1'b1;
      else if (npBusy && !selPend) npBusy <= 1'b0;
    end else begin
      npBusy <= 1'b0;
    end
  end

endmodule

// File: rtl/psb_datapath.sv
module psb_datapath #(
  parameter int NREG       = 10,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int POSTED_BIT = 2
) (
  input  logic                     busClk,
  input  logic                     busRstN,
  input  logic                     funcClk,
  input  logic                     funcRstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  input  psb_pkg::psbStb_t         stb,
  input  logic [ADDR_W-1:0]        pendAddr,
  input  logic [ADDR_W-1:0]        ifcAddr,
  output logic [NREG-1:0]          pendVec,
  output logic                     postedMode,
  output logic [DATA_W-1:0]        busRdata,
  output logic [NREG*DATA_W-1:0]   funcRegs,
  output logic [NREG-1:0]          funcWrStb
);

  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  logic [DATA_W-1:0] shadowArr [NREG];

  // Posted-mode bit, reset to posted
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)      postedMode <= 1'b1;
    else if (stb.ctlWr) postedMode <= busWdata[POSTED_BIT];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    logic [DATA_W-1:0] holdQ;
    logic [DATA_W-1:0] shadowQ;
    logic [DATA_W-1:0] funcQ;
    logic reqTog, ackS1, ackS2;
    logic reqS1, reqS2, ackTog, stbQ;
    logic hit;

    assign hit = stb.launch && (busAddr == MY_ADDR);

    // Bus side: hold value, request toggle, acknowledge synchronizer
    always_ff @(posedge busClk or negedge busRstN) begin
      if (!busRstN) begin
        holdQ   <= '0;
        shadowQ <= '0;
        reqTog  <= 1'b0;
        ackS1   <= 1'b0;
        ackS2   <= 1'b0;
      end else begin
        if (hit) begin
          holdQ  <= busWdata;
          reqTog <= ~reqTog;
        end
        ackS1 <= ackTog;
        ackS2 <= ackS1;
        if (ackS1 != ackS2) shadowQ <= holdQ;
      end
    end

    // Functional side: request synchronizer, capture and acknowledge
    always_ff @(posedge funcClk or negedge funcRstN) begin
      if (!funcRstN) begin
        reqS1  <= 1'b0;
        reqS2  <= 1'b0;
        ackTog <= 1'b0;
        funcQ  <= '0;
        stbQ   <= 1'b0;
      end else begin
        reqS1 <= reqTog;
        reqS2 <= reqS1;
        stbQ  <= 1'b0;
        if (reqS2 != ackTog) begin
          ackTog <= reqS2;
          funcQ  <= holdQ;
          stbQ   <= 1'b1;
        end
      end
    end

    assign pendVec[i]                    = reqTog ^ ackS2;
    assign shadowArr[i]                  = shadowQ;
    assign funcRegs[i*DATA_W +: DATA_W]  = funcQ;
    assign funcWrStb[i]                  = stbQ;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr < NREG_A) begin
      busRdata = shadowArr[busAddr];
    end else if (busAddr == pendAddr) begin
      busRdata[NREG-1:0] = pendVec;
    end else if (busAddr == ifcAddr) begin
      busRdata[POSTED_BIT] = postedMode;
    end
  end

endmodule

// File: rtl/psb_bridge.sv
module psb_bridge #(
  parameter int NREG       = 10,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int POSTED_BIT = 2,
  parameter int PEND_ADDR  = 14,
  parameter int IFC_ADDR   = 15
) (
  input  logic                    busClk,
  input  logic                    busRstN,
  input  logic                    busSel,
  input  logic                    busWr,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  output logic                    busReady,
  input  logic                    funcClk,
  input  logic                    funcRstN,
  output logic [NREG*DATA_W-1:0]  funcRegs,
  output logic [NREG-1:0]         funcWrStb
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADDR);
  localparam logic [ADDR_W-1:0] IFC_A  = ADDR_W'(IFC_ADDR);

  psb_pkg::psbStb_t stb;
  logic [NREG-1:0]  pendVec;
  logic             postedMode;

  psb_ctrl #(.NREG(NREG), .ADDR_W(ADDR_W)) u_ctrl (
    .busClk(busClk), .busRstN(busRstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .pendVec(pendVec), .postedMode(postedMode),
    .ifcAddr(IFC_A), .busReady(busReady), .stb(stb)
  );

  psb_datapath #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .POSTED_BIT(POSTED_BIT)) u_dp (
    .busClk(busClk), .busRstN(busRstN), .funcClk(funcClk), .funcRstN(funcRstN),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb),
    .pendAddr(PEND_A), .ifcAddr(IFC_A), .pendVec(pendVec),
    .postedMode(postedMode), .busRdata(busRdata),
    .funcRegs(funcRegs), .funcWrStb(funcWrStb)
  );

endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int NREG   = 10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              busClk,
  input logic              busRstN,
  input logic              funcClk,
  input logic              funcRstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              busReady,
  input logic [NREG-1:0]   pendVec,
  input logic              postedMode,
  input logic [NREG-1:0]   funcWrStb
);

  localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NREG);

  // R6: a write to a register still in flight never completes
  p_held_while_pending_r6: assert property (@(posedge busClk) disable iff (!busRstN)
    (busSel && busWr && (busAddr < NREG_A) && pendVec[busAddr]) |-> !busReady);

  // R7: a non-posted synchronised write never completes in its first cycle
  p_nonposted_stall_r7: assert property (@(posedge busClk) disable iff (!busRstN)
    (busSel && busWr && (busAddr < NREG_A) && !postedMode && busReady)
      |-> $past(busSel && busWr && !busReady));

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);

    // R2: a flag only rises after a write to its own address
    p_pend_rise_r2: assert property (@(posedge busClk) disable iff (!busRstN)
      $rose(pendVec[i]) |-> $past(busSel && busWr && busAddr == MY_ADDR));

    // R4: update strobe lasts a single functional cycle
    p_stb_pulse_r4: assert property (@(posedge funcClk) disable iff (!funcRstN)
      funcWrStb[i] |=> !funcWrStb[i]);

    // R10: the shadow read stays put while its transfer is in flight
    p_shadow_stable_r10: assert property (@(posedge busClk) disable iff (!busRstN)
      (busSel && !busWr && busAddr == MY_ADDR && pendVec[i] &&
       $past(busSel && !busWr && busAddr == MY_ADDR && pendVec[i]))
        |-> $stable(busRdata));
  end

endmodule

bind psb_bridge psb_checker #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_psbChk (
  .busClk(busClk), .busRstN(busRstN), .funcClk(funcClk), .funcRstN(funcRstN),
  .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busRdata(busRdata),
  .busReady(busReady), .pendVec(pendVec), .postedMode(postedMode),
  .funcWrStb(funcWrStb)
);

// File: tb/tb_psb_bridge.sv
module tb_psb_bridge;
  localparam int NREG = 10;
  localparam int DW   = 32;
  localparam int AW   = 4;
  localparam logic [AW-1:0] PEND_A = 4'hE;
  localparam logic [AW-1:0] IFC_A  = 4'hF;

  logic bclk = 1'b0, fclk = 1'b0, bRstN = 1'b0, fRstN = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ready;
  logic [NREG*DW-1:0] fRegs;
  logic [NREG-1:0] fStb;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5  bclk = ~bclk;   // 100 MHz
  always #20 fclk = ~fclk;   // 25 MHz, edges never meet bclk rises

  psb_bridge dut (
    .busClk(bclk), .busRstN(bRstN), .busSel(sel), .busWr(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata), .busReady(ready), .funcClk(fclk),
    .funcRstN(fRstN), .funcRegs(fRegs), .funcWrStb(fStb)
  );

  // ---------------- reference model ----------------
  bit            mPend [NREG];
  int            mF [NREG];
  int            mB [NREG];
  logic [DW-1:0] mHold [NREG];
  logic [DW-1:0] mShadow [NREG];
  logic [DW-1:0] mFunc [NREG];
  bit            mStb [NREG];
  bit            mPosted, mNp;

  function bit mSync();
    return sel && wr && (addr < AW'(NREG));
  endfunction
  function bit mSelPend();
    return (addr < AW'(NREG)) ? mPend[addr] : 1'b0;
  endfunction
  function bit mReady();
    if (!mSync()) return 1'b1;
    if (mPosted) return !mSelPend();
    return mNp && !mSelPend();
  endfunction
  function logic [DW-1:0] mRdata();
    logic [DW-1:0] v;
    v = '0;
    if (addr < AW'(NREG)) v = mShadow[addr];
    else if (addr == PEND_A) for (int i = 0; i < NREG; i++) v[i] = mPend[i];
    else if (addr == IFC_A) v[2] = mPosted;
    return v;
  endfunction

  always @(posedge bclk) begin
    if (!bRstN) begin
      mPosted = 1; mNp = 0;
      for (int i = 0; i < NREG; i++) begin
        mPend[i] = 0; mB[i] = 0; mHold[i] = '0; mShadow[i] = '0;
      end
    end else begin
      bit launch, sp;
      sp = mSelPend();
      launch = mSync() && !sp && (mPosted || !mNp);
      if (mSync() && !mPosted) begin
        if (!mNp && !sp) mNp = 1;
        else if (mNp && !sp) mNp = 0;
      end else mNp = 0;
      for (int i = 0; i < NREG; i++)
        if (mPend[i] && mF[i] == 3) begin
          mB[i]++;
          if (mB[i] == 2) begin
            mPend[i] = 0; mShadow[i] = mHold[i]; mB[i] = 0; mF[i] = 0;
          end
        end
      if (launch) begin
        mHold[addr] = wdata; mPend[addr] = 1; mF[addr] = 0; mB[addr] = 0;
      end
      if (sel && wr && addr == IFC_A) mPosted = wdata[2];
    end
  end

  always @(posedge fclk) begin
    if (!fRstN) begin
      for (int i = 0; i < NREG; i++) begin mF[i] = 0; mFunc[i] = '0; mStb[i] = 0; end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        mStb[i] = 0;
        if (mPend[i] && mF[i] < 3) begin
          mF[i]++;
          if (mF[i] == 3) begin mFunc[i] = mHold[i]; mStb[i] = 1; end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge bclk) begin
    if (bRstN && !done) begin
      string tg;
      #3;
      if (!mSync()) tg = (addr == PEND_A) ? "R9" : "R8";
      else if (!mPosted) tg = "R7";
      else tg = mSelPend() ? "R6" : "R5";
      check(ready === mReady(), tg, {31'd0, ready}, {31'd0, mReady()});
      check(rdata === mRdata(), (addr < AW'(NREG)) ? "R10" : "R9", rdata, mRdata());
      for (int i = 0; i < NREG; i++)
        check(fRegs[i*DW +: DW] === mFunc[i], "R3", fRegs[i*DW +: DW], mFunc[i]);
    end
  end

  always @(negedge fclk) begin
    if (fRstN && !done) begin
      #3;
      for (int i = 0; i < NREG; i++)
        check(fStb[i] === mStb[i], "R4", {31'd0, fStb[i]}, {31'd0, mStb[i]});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, output int n);
    bit r;
    n = 0;
    @(negedge bclk); sel = 1; wr = 1; addr = a; wdata = d;
    do begin #2; r = ready; @(posedge bclk); n++; end while (!r);
    #1; sel = 0; wr = 0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge bclk); sel = 1; wr = 0; addr = a;
    #2; d = rdata;
    @(posedge bclk); #1; sel = 0;
  endtask

  task automatic waitIdle();
    logic [DW-1:0] v;
    for (int k = 0; k < 300; k++) begin
      busRead(PEND_A, v);
      if (v == '0) break;
    end
  endtask

  // watchdog
  always @(posedge bclk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int n, n2;
    #53; bRstN = 1; fRstN = 1;

    // R1: reset state
    busRead(PEND_A, v); check(v == 0, "R1 pending", v, 0);
    busRead(IFC_A, v);  check(v == 32'h4, "R1 ifctrl", v, 32'h4);
    for (int i = 0; i < NREG; i++) begin
      busRead(AW'(i), v); check(v == 0, "R1 shadow", v, 0);
    end
    check(fRegs == '0, "R1 func", fRegs[DW-1:0], 0);

    // R2 / R5 / R10 / R3: single posted write to the trigger register (bit 3)
    busWrite(4'd3, 32'hDEAD_0003, n);
    check(n == 1, "R5 one cycle", n, 1);
    busRead(PEND_A, v); check(v == 32'h8, "R2 bit3", v, 32'h8);
    busRead(4'd3, v);   check(v == 0, "R10 old value", v, 0);
    waitIdle();
    busRead(4'd3, v);   check(v == 32'hDEAD_0003, "R10 new value", v, 32'hDEAD_0003);
    check(fRegs[3*DW +: DW] == 32'hDEAD_0003, "R3 func copy", fRegs[3*DW +: DW], 32'hDEAD_0003);

    // R6: back-to-back writes to the counter register
    busWrite(4'd1, 32'h1111_0001, n);
    busWrite(4'd1, 32'h1111_0002, n2);
    check(n2 > 2, "R6 held off", n2, 3);
    waitIdle();
    busRead(4'd1, v); check(v == 32'h1111_0002, "R6 final", v, 32'h1111_0002);

    // R11: three registers in flight together
    busWrite(4'd0, 32'hA0, n);
    busWrite(4'd5, 32'hA5, n);
    busWrite(4'd9, 32'hA9, n);
    busRead(PEND_A, v); check(v == 32'h221, "R11 flags", v, 32'h221);
    waitIdle();

    // R9: the status register ignores writes
    busWrite(PEND_A, 32'hFFFF_FFFF, n);
    check(n == 1, "R9 no stall", n, 1);
    busRead(PEND_A, v); check(v == 0, "R9 read-only", v, 0);
    busRead(4'd12, v);  check(v == 0, "R10 unmapped", v, 0);

    // R8 / R7: non-posted mode
    busWrite(IFC_A, 32'hFFFF_FFFB, n);
    busRead(IFC_A, v); check(v == 0, "R8 clear posted", v, 0);
    busWrite(4'd7, 32'h7777_0007, n);
    check(n >= 5, "R7 stall length", n, 5);
    busRead(PEND_A, v); check(v == 0, "R7 done on return", v, 0);
    check(fRegs[7*DW +: DW] == 32'h7777_0007, "R7 func copy", fRegs[7*DW +: DW], 32'h7777_0007);

    // R7: non-posted write behind an outstanding posted write
    busWrite(IFC_A, 32'h4, n);
    busWrite(4'd2, 32'h2222_0001, n);
    busWrite(IFC_A, 32'h0, n);
    busWrite(4'd2, 32'h2222_0002, n2);
    check(n2 >= 7, "R7 waits both", n2, 7);
    busRead(4'd2, v); check(v == 32'h2222_0002, "R7 final", v, 32'h2222_0002);

    // patterns on every register in posted mode
    busWrite(IFC_A, 32'h4, n);
    busRead(IFC_A, v); check(v == 32'h4, "R8 set posted", v, 32'h4);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NREG; i++) busWrite(AW'(i), (32'h0101_0101 * (k*NREG + i)) ^ 32'h5A5A_A5A5, n);
      waitIdle();
      for (int i = 0; i < NREG; i++) begin
        busRead(AW'(i), v);
        check(v == ((32'h0101_0101 * (k*NREG + i)) ^ 32'h5A5A_A5A5), "R2 pattern", v,
              (32'h0101_0101 * (k*NREG + i)) ^ 32'h5A5A_A5A5);
      end
    end

    repeat (20) @(negedge bclk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule